// File: doc/BRIEF.md
# Hashed Page Table Group Address Generator

This block turns a virtual segment identifier and an effective address into the two physical addresses of the page-table entry groups that a hardware table walker must search, together with the tag it compares against each entry. The primary group comes from a hash of the segment identifier and the page index. The secondary group uses the bitwise complement of that hash. Both hashes are masked down to the size of the table, which is taken from a table descriptor word. The descriptor also supplies the base address of the table.

A mode input picks one of two table formats. The narrow format has 8-byte entries, and its table size comes from a 9-bit mask field. The wide format has 16-byte entries, and its table size comes from a 5-bit log2 field. A log value above the supported maximum is raised on an error flag and clamped to that maximum. Each request is marked by a valid strobe. The results appear on registered outputs in the next cycle, together with a valid strobe, and they hold until the next request.

Top module: `hpt_group_gen`

## Requirements
- R1: `outValid` is 1 in exactly the cycles that follow a clock edge at which `inValid` was 1. The results of that request are on the outputs in the same cycle.
- R2: While no request is accepted, `outGroupPri`, `outGroupSec`, `outTag` and `outSizeErr` keep their last values.
- R3: Narrow mode (`inMode64`=0): hash = ((vsid XOR pageIdx) << 6) AND a mask of 19 ones at bits 24:6. The size mask is `inTableDesc[8:0]`. The combined mask is (size mask << 16) OR ones at bits 15:6. The group address is (`inTableDesc` with bits 15:0 cleared) OR (hash AND combined mask).
- R4: Wide mode (`inMode64`=1): hash = ((vsid XOR pageIdx) << 7) AND a mask of 39 ones at bits 45:7. L is `inTableDesc[4:0]`. The size mask is (2^28-1) >> (28-L). The combined mask is (size mask << 18) OR ones at bits 17:7. The group address is (`inTableDesc` with bits 17:0 cleared) OR (hash AND combined mask).
- R5: The secondary group address uses (NOT hash) AND the same hash mask, with the same base and combined mask as the primary.
- R6: pageIdx = (`inEa` AND `inSegMask`) >> 12.
- R7: Wide-mode tag = (vsid << 12) OR ((pageIdx >> 4) AND 0xF80). Only five page-index bits reach the tag.
- R8: Narrow-mode tag = (vsid << 7) OR ((pageIdx >> 10) AND 0x3F).
- R9: In wide mode, L > 28 sets `outSizeErr` and is treated as L = 28. In narrow mode `outSizeErr` is 0.
- R10: During and just after reset, `outValid` and all result outputs are 0.
- R11: In narrow mode, descriptor bits 15:9 do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inMode64 | input | 1 | 1 selects the wide table format |
| inVsid | input | 52 | Virtual segment identifier |
| inEa | input | 64 | Effective address |
| inSegMask | input | 64 | Mask of the address bits that lie inside the segment |
| inTableDesc | input | 64 | Table descriptor: base address and size field |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outGroupPri | output | 64 | Primary group address |
| outGroupSec | output | 64 | Secondary group address |
| outTag | output | 64 | Entry compare tag |
| outSizeErr | output | 1 | Wide-mode log size field was out of range |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, a 52-bit VSID, a 5-bit log field with a maximum of 28, and a 9-bit narrow size field. The 5-bit field can encode 29 to 31, so these defaults let the bench reach the clamp and error path directly. They also cover the smallest wide table (L=0) and the largest (L=28). With a full-width VSID, hash bits reach the top of the 39-bit wide-mode hash mask, while the narrow mask cuts the same values off at bit 24.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // register a new result this cycle
    logic mode64;   // wide table format selected
  } hptStrobeT;

endpackage

// File: rtl/hpt_ctrl.sv
module hpt_ctrl
  import hpt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inMode64,
  output hptStrobeT strobe,
  output logic      outValid
);

  assign strobe.capture = inValid;
  assign strobe.mode64  = inMode64;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1: result strobe follows request by exactly one cycle
  assert_latency_hi_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_latency_lo_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/hpt_sizedec.sv
module hpt_sizedec #(
  parameter int ADDR_W  = 64,
  parameter int SZ32_W  = 9,
  parameter int LOG_W   = 5,
  parameter int LOG_MAX = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode64,
  input  logic [SZ32_W-1:0] sizeField,
  output logic [ADDR_W-1:0] sizeMask,
  output logic              overflow
);

  localparam logic [ADDR_W-1:0] FULL = (ADDR_W'(1) << LOG_MAX) - ADDR_W'(1);

  logic [LOG_W-1:0] logRaw;
  logic [LOG_W-1:0] logEff;

  assign logRaw   = sizeField[LOG_W-1:0];
  assign overflow = mode64 && (int'(logRaw) > LOG_MAX);
  assign logEff   = overflow ? LOG_W'(LOG_MAX) : logRaw;

  always_comb begin
    if (mode64) sizeMask = FULL >> (LOG_W'(LOG_MAX) - logEff);
    else        sizeMask = ADDR_W'(sizeField);
  end

  // R9: a wide-mode size mask never exceeds the clamp limit
  assert_clamp_R9: assert property (@(posedge clk) disable iff (!rstN)
    mode64 |-> ($countones(sizeMask) <= LOG_MAX));

endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int ADDR_W    = 64,
  parameter int VSID_W    = 52,
  parameter int HASH_SH   = 6,
  parameter int HASH_W    = 19,
  parameter int BASE_SH   = 16,
  parameter int TAG_VSH   = 7,
  parameter int TAG_PSH   = 10,
  parameter int TAG_PLO   = 0,
  parameter int TAG_PW    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VSID_W-1:0] vsid,
  input  logic [ADDR_W-1:0] pageIdx,
  input  logic [ADDR_W-1:0] sizeMask,
  input  logic [ADDR_W-1:0] desc,
  output logic [ADDR_W-1:0] groupPri,
  output logic [ADDR_W-1:0] groupSec,
  output logic [ADDR_W-1:0] tag
);

  localparam logic [ADDR_W-1:0] HASH_MASK =
    ((ADDR_W'(1) << HASH_W) - ADDR_W'(1)) << HASH_SH;
  localparam logic [ADDR_W-1:0] LOW_MASK =
    ((ADDR_W'(1) << (BASE_SH - HASH_SH)) - ADDR_W'(1)) << HASH_SH;
  localparam logic [ADDR_W-1:0] BASE_KEEP =
    ~((ADDR_W'(1) << BASE_SH) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] TAG_PMASK =
    ((ADDR_W'(1) << TAG_PW) - ADDR_W'(1)) << TAG_PLO;

  logic [ADDR_W-1:0] vsidExt;
  logic [ADDR_W-1:0] hashPri;
  logic [ADDR_W-1:0] hashSec;
  logic [ADDR_W-1:0] combMask;
  logic [ADDR_W-1:0] tblBase;

  assign vsidExt  = ADDR_W'(vsid);
  assign hashPri  = ((vsidExt ^ pageIdx) << HASH_SH) & HASH_MASK;
  assign hashSec  = ~hashPri & HASH_MASK;
  assign combMask = (sizeMask << BASE_SH) | LOW_MASK;
  assign tblBase  = desc & BASE_KEEP;
  assign groupPri = tblBase | (hashPri & combMask);
  assign groupSec = tblBase | (hashSec & combMask);
  assign tag      = (vsidExt << TAG_VSH) | ((pageIdx >> TAG_PSH) & TAG_PMASK);

  // R5: both groups share every bit outside the hashed window
  assert_sec_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((groupPri ^ groupSec) & ~combMask) == '0);

endmodule

// File: rtl/hpt_datapath.sv
module hpt_datapath
  import hpt_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VSID_W  = 52,
  parameter int PAGE_SH = 12,
  parameter int H32_SH  = 6,
  parameter int H32_W   = 19,
  parameter int B32_SH  = 16,
  parameter int SZ32_W  = 9,
  parameter int H64_SH  = 7,
  parameter int H64_W   = 39,
  parameter int B64_SH  = 18,
  parameter int LOG_W   = 5,
  parameter int LOG_MAX = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  hptStrobeT         strobe,
  input  logic [VSID_W-1:0] inVsid,
  input  logic [ADDR_W-1:0] inEa,
  input  logic [ADDR_W-1:0] inSegMask,
  input  logic [ADDR_W-1:0] inTableDesc,
  output logic [ADDR_W-1:0] groupPriQ,
  output logic [ADDR_W-1:0] groupSecQ,
  output logic [ADDR_W-1:0] tagQ,
  output logic              sizeErrQ
);

  localparam int NFMT = 2;  // index 0: narrow, index 1: wide

  logic [ADDR_W-1:0] pageIdx;
  logic [ADDR_W-1:0] sizeMask;
  logic              sizeOvf;
  logic [ADDR_W-1:0] priFmt [NFMT];
  logic [ADDR_W-1:0] secFmt [NFMT];
  logic [ADDR_W-1:0] tagFmt [NFMT];

  assign pageIdx = (inEa & inSegMask) >> PAGE_SH;

  hpt_sizedec #(
    .ADDR_W(ADDR_W), .SZ32_W(SZ32_W), .LOG_W(LOG_W), .LOG_MAX(LOG_MAX)
  ) sizedec_i (
    .clk(clk), .rstN(rstN), .mode64(strobe.mode64),
    .sizeField(inTableDesc[SZ32_W-1:0]),
    .sizeMask(sizeMask), .overflow(sizeOvf)
  );

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    if (f == 0) begin : g_narrow
      hpt_hash #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .HASH_SH(H32_SH), .HASH_W(H32_W),
        .BASE_SH(B32_SH), .TAG_VSH(7), .TAG_PSH(10), .TAG_PLO(0), .TAG_PW(6)
      ) hash_i (
        .clk(clk), .rstN(rstN), .vsid(inVsid), .pageIdx(pageIdx),
        .sizeMask(sizeMask), .desc(inTableDesc),
        .groupPri(priFmt[f]), .groupSec(secFmt[f]), .tag(tagFmt[f])
      );
    end else begin : g_wide
      hpt_hash #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .HASH_SH(H64_SH), .HASH_W(H64_W),
        .BASE_SH(B64_SH), .TAG_VSH(12), .TAG_PSH(4), .TAG_PLO(7), .TAG_PW(5)
      ) hash_i (
        .clk(clk), .rstN(rstN), .vsid(inVsid), .pageIdx(pageIdx),
        .sizeMask(sizeMask), .desc(inTableDesc),
        .groupPri(priFmt[f]), .groupSec(secFmt[f]), .tag(tagFmt[f])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupPriQ <= '0;
      groupSecQ <= '0;
      tagQ      <= '0;
      sizeErrQ  <= 1'b0;
    end else if (strobe.capture) begin
      groupPriQ <= priFmt[strobe.mode64];
      groupSecQ <= secFmt[strobe.mode64];
      tagQ      <= tagFmt[strobe.mode64];
      sizeErrQ  <= sizeOvf;
    end
  end

  // R2: results hold while no request is captured
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(groupPriQ) && $stable(groupSecQ) &&
                         $stable(tagQ) && $stable(sizeErrQ)));

  // R9: narrow-mode requests never flag a size error
  assert_no_err32_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.mode64) |=> !sizeErrQ);

endmodule

// File: rtl/hpt_group_gen.sv
module hpt_group_gen
  import hpt_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VSID_W  = 52,
  parameter int PAGE_SH = 12,
  parameter int H32_SH  = 6,
  parameter int H32_W   = 19,
  parameter int B32_SH  = 16,
  parameter int SZ32_W  = 9,
  parameter int H64_SH  = 7,
  parameter int H64_W   = 39,
  parameter int B64_SH  = 18,
  parameter int LOG_W   = 5,
  parameter int LOG_MAX = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inMode64,
  input  logic [VSID_W-1:0] inVsid,
  input  logic [ADDR_W-1:0] inEa,
  input  logic [ADDR_W-1:0] inSegMask,
  input  logic [ADDR_W-1:0] inTableDesc,
  output logic              outValid,
  output logic [ADDR_W-1:0] outGroupPri,
  output logic [ADDR_W-1:0] outGroupSec,
  output logic [ADDR_W-1:0] outTag,
  output logic              outSizeErr
);

  hptStrobeT strobe;

  hpt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode64(inMode64),
    .strobe(strobe), .outValid(outValid)
  );

  hpt_datapath #(
    .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PAGE_SH(PAGE_SH),
    .H32_SH(H32_SH), .H32_W(H32_W), .B32_SH(B32_SH), .SZ32_W(SZ32_W),
    .H64_SH(H64_SH), .H64_W(H64_W), .B64_SH(B64_SH),
    .LOG_W(LOG_W), .LOG_MAX(LOG_MAX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inVsid(inVsid), .inEa(inEa), .inSegMask(inSegMask),
    .inTableDesc(inTableDesc),
    .groupPriQ(outGroupPri), .groupSecQ(outGroupSec),
    .tagQ(outTag), .sizeErrQ(outSizeErr)
  );

endmodule

// File: tb/hpt_group_gen_tb_top.sv
module hpt_group_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inMode64 = 1'b0;
  logic [51:0] inVsid = '0;
  logic [63:0] inEa = '0;
  logic [63:0] inSegMask = '0;
  logic [63:0] inTableDesc = '0;
  logic        outValid;
  logic [63:0] outGroupPri;
  logic [63:0] outGroupSec;
  logic [63:0] outTag;
  logic        outSizeErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hpt_group_gen dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode64(inMode64),
    .inVsid(inVsid), .inEa(inEa), .inSegMask(inSegMask),
    .inTableDesc(inTableDesc), .outValid(outValid),
    .outGroupPri(outGroupPri), .outGroupSec(outGroupSec),
    .outTag(outTag), .outSizeErr(outSizeErr)
  );

  // Expected values, written from the requirements
  logic [63:0] expPri, expSec, expTag;
  logic        expErr;

  task automatic refModel(input logic m64, input logic [51:0] v,
                          input logic [63:0] ea, input logic [63:0] sm,
                          input logic [63:0] d);
    logic [63:0] pg, hmask, hp, hs, szm, cm, base, lowm;
    int hsh, bsh, hw, lg;
    pg = (ea & sm) >> 12;                                   // R6
    if (m64) begin hsh = 7; bsh = 18; hw = 39; end          // R4
    else     begin hsh = 6; bsh = 16; hw = 19; end          // R3
    hmask = ((64'd1 << hw) - 1) << hsh;
    hp = (({12'd0, v} ^ pg) << hsh) & hmask;
    hs = ~hp & hmask;                                       // R5
    expErr = 1'b0;
    if (m64) begin
      lg = int'(d[4:0]);
      if (lg > 28) begin expErr = 1'b1; lg = 28; end        // R9
      szm = 64'h0FFF_FFFF >> (28 - lg);
    end else begin
      szm = {55'd0, d[8:0]};
    end
    lowm = ((64'd1 << (bsh - hsh)) - 1) << hsh;
    cm   = (szm << bsh) | lowm;
    base = d & ~((64'd1 << bsh) - 1);
    expPri = base | (hp & cm);
    expSec = base | (hs & cm);
    if (m64) expTag = ({12'd0, v} << 12) | ((pg >> 4) & 64'hF80);  // R7
    else     expTag = ({12'd0, v} << 7)  | ((pg >> 10) & 64'h3F);  // R8
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, "valid", {63'd0, outValid}, 64'd1);
    chk(req, "pri", outGroupPri, expPri);
    chk(req, "sec", outGroupSec, expSec);
    chk(req, "tag", outTag, expTag);
    chk(req, "err", {63'd0, outSizeErr}, {63'd0, expErr});
  endtask

  // Drive one request at a falling edge; results are sampled one cycle later
  task automatic issue(input logic m64, input logic [51:0] v,
                       input logic [63:0] ea, input logic [63:0] sm,
                       input logic [63:0] d);
    @(negedge clk);
    inValid = 1'b1; inMode64 = m64; inVsid = v; inEa = ea;
    inSegMask = sm; inTableDesc = d;
    @(negedge clk);
    inValid = 1'b0;
    refModel(m64, v, ea, sm, d);
  endtask

  task automatic t_reset;
    chk("R10", "valid", {63'd0, outValid}, 64'd0);
    chk("R10", "pri", outGroupPri, 64'd0);
    chk("R10", "sec", outGroupSec, 64'd0);
    chk("R10", "tag", outTag, 64'd0);
    chk("R10", "err", {63'd0, outSizeErr}, 64'd0);
  endtask

  task automatic t_narrow;
    issue(1'b0, 52'h0_0000_00AB_CDEF, 64'h0000_0000_1234_5678,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FF0_01FF);
    chkAll("R3_R5_R8");
    issue(1'b0, 52'hF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F000,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_1234_0003);
    chkAll("R3_R5_R8");
  endtask

  task automatic t_wide;
    issue(1'b1, 52'h1_2345_6789_ABCD, 64'h0123_4567_89AB_CDEF,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0012_3400_0010);
    chkAll("R4_R5_R7");
    issue(1'b1, 52'hF_FFFF_FFFF_FFFF, 64'h0000_0000_0FFF_F000,
          64'h0000_0000_0FFF_FFFF, 64'hABCD_0000_0000_0005);
    chkAll("R4_R5_R7");
  endtask

  task automatic t_logsizes;
    for (int lg = 0; lg <= 28; lg += 7) begin
      issue(1'b1, 52'h0_00A5_A5A5_A5A5, 64'h0000_0000_05A5_A000,
            64'h0000_0000_0FFF_FFFF, 64'h0000_0F00_0000_0000 | 64'(lg));
      chkAll("R4");
    end
  endtask

  task automatic t_overflow;
    for (int lg = 29; lg <= 31; lg++) begin
      issue(1'b1, 52'h5_5555_5555_5555, 64'h0000_0000_0AAA_A000,
            64'h0000_0000_0FFF_FFFF, 64'h0000_4000_0000_0000 | 64'(lg));
      chkAll("R9");
      chk("R9", "err_set", {63'd0, outSizeErr}, 64'd1);
    end
    issue(1'b0, 52'h0_0000_0012_3456, 64'h0000_0000_0000_1000,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0000_001F);
    chk("R9", "err_narrow", {63'd0, outSizeErr}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] p, s, t;
    issue(1'b1, 52'h0_0000_0BAD_BEEF, 64'h0000_0000_0123_4000,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0100_0003);
    chkAll("R2");
    p = outGroupPri; s = outGroupSec; t = outTag;
    inMode64 = 1'b0; inVsid = 52'hF_0F0F_0F0F_0F0F; inEa = 64'hFFFF_FFFF_FFFF_FFFF;
    inTableDesc = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "pri_hold", outGroupPri, p);
      chk("R2", "sec_hold", outGroupSec, s);
      chk("R2", "tag_hold", outTag, t);
      chk("R1", "valid_low", {63'd0, outValid}, 64'd0);
    end
  endtask

  task automatic t_backtoback;
    logic [63:0] p1, s1, t1;
    @(negedge clk);
    inValid = 1'b1; inMode64 = 1'b0; inVsid = 52'h0_0000_0000_1111;
    inEa = 64'h0000_0000_0222_2000; inSegMask = 64'h0000_0000_0FFF_FFFF;
    inTableDesc = 64'h0000_0000_0050_000F;
    refModel(1'b0, 52'h0_0000_0000_1111, 64'h0000_0000_0222_2000,
             64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0050_000F);
    p1 = expPri; s1 = expSec; t1 = expTag;
    @(negedge clk);
    chk("R1", "valid_first", {63'd0, outValid}, 64'd1);
    chk("R1", "pri_first", outGroupPri, p1);
    chk("R1", "sec_first", outGroupSec, s1);
    chk("R1", "tag_first", outTag, t1);
    inMode64 = 1'b1; inVsid = 52'h0_0033_3333_3333;
    inEa = 64'h0000_0000_0444_4000; inTableDesc = 64'h0000_0066_0000_0014;
    @(negedge clk);
    inValid = 1'b0;
    refModel(1'b1, 52'h0_0033_3333_3333, 64'h0000_0000_0444_4000,
             64'h0000_0000_0FFF_FFFF, 64'h0000_0066_0000_0014);
    chkAll("R1");
    @(negedge clk);
    chk("R1", "valid_drop", {63'd0, outValid}, 64'd0);
  endtask

  task automatic t_ignore32;
    logic [63:0] p, s, t;
    issue(1'b0, 52'h0_0000_00C0_FFEE, 64'h0000_0000_0765_4000,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0012_0007);
    p = outGroupPri; s = outGroupSec; t = outTag;
    issue(1'b0, 52'h0_0000_00C0_FFEE, 64'h0000_0000_0765_4000,
          64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0012_FE07);
    chk("R11", "pri", outGroupPri, p);
    chk("R11", "sec", outGroupSec, s);
    chk("R11", "tag", outTag, t);
  endtask

  task automatic t_segmask;
    issue(1'b1, 52'h0_0000_0000_0001, 64'hFFFF_FFFF_FFFF_F000,
          64'h0000_0000_0000_0000, 64'h0000_0000_0000_001C);
    chkAll("R6");
    issue(1'b1, 52'h0_0000_0000_0001, 64'hFFFF_FFFF_FFFF_F000,
          64'h0000_0000_00FF_FFFF, 64'h0000_0000_0000_001C);
    chkAll("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_logsizes();
    t_overflow();
    t_hold();
    t_backtoback();
    t_ignore32();
    t_segmask();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule